// File: doc/BRIEF.md
# Clock Synthesizer Ratio Search Engine

This block chooses the multiplier and divider settings of a pixel clock synthesizer so that the generated rate lands as close as possible to a requested rate. A controller gives it a reference frequency and a target rate, then pulses a start input. The engine tries every multiplier/divider pair from the top code down to one. For each pair it computes the rate the pair would produce, using two integer divisions done by multi-cycle shift-and-subtract dividers, and it keeps the pair with the smallest absolute distance from the target.

When the last pair has been tried, the engine packs the winning pair into a synthesizer control word and raises a one-cycle completion pulse. The word then stays unchanged until the next search completes. The product of multiplier and reference is divided by the fixed scale only once per multiplier value. The divider setting is then swept against that scaled value.

Top module: `fsyn_search`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy and done are low and the result word is zero.
- R2: A start pulse while idle captures the reference and target inputs and raises busy in the next cycle. Later changes on those inputs have no effect on the running search.
- R3: A start pulse while busy is ignored. The running search finishes with the inputs it captured, and its result is unchanged.
- R4: The rate of a pair (m, d) is floor(floor(m * fref / 1000) / d), with the product formed at full width.
- R5: Multiplier m is the outer loop and d the inner loop. Both run from CODE_MAX down to 1, and every pair is evaluated exactly once per search.
- R6: The chosen pair minimises |rate - target| over all pairs.
- R7: A pair replaces the current best when its error is less than or equal to the best error. The best error starts at its all-ones maximum. Among equal errors the pair evaluated last wins: the smallest m, then the smallest d.
- R8: The 14-bit result word holds m-1 in bits 13:8 and d-1 in bits 5:0. Bits 7:6 are zero. m and d are clamped to 1..63 before encoding.
- R9: done is high for exactly one cycle, in the cycle where busy has just fallen. The word changes only together with done and holds its value between searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; acted on only while idle |
| fref_i | input | FREF_W | Reference frequency, captured at start |
| target_i | input | TGT_W | Requested rate, captured at start |
| busy_o | output | 1 | High from the cycle after an accepted start until completion |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 14 | Encoded multiplier/divider control word |

## Verification
The bench targets ties. With a reference of 1000 and a target of zero, many pairs produce a zero rate. A design that replaced the best only on strictly smaller error, or scanned in ascending order, would return a larger pair than code 0x001. A target far above any reachable rate must give the top multiplier with divider one. A design that clipped the scan range or lost the top multiplier bit would return a smaller word.

A second start pulse, carrying different inputs, is issued in the middle of a search. A design that restarted or recaptured would return the answer for the second inputs. Random references and targets are checked against a bench model of the full scan, which catches any truncation or off-by-one in either division.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;

  localparam int unsigned CODE_W = 6;
  localparam int unsigned WORD_W = 14;
  localparam int unsigned MULT_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_M,
    ST_WAIT_M,
    ST_LOAD_D,
    ST_WAIT_D,
    ST_FINISH
  } fsyn_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fsyn_divider.sv
module fsyn_divider #(
  parameter int unsigned N_W = 26,
  parameter int unsigned D_W = 10,
  parameter int unsigned O_W = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [N_W-1:0] dividend_i,
  input  logic [D_W-1:0] divisor_i,
  output logic [O_W-1:0] quot_o,
  output logic           ready_o
);

  localparam int unsigned CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   quo_q, quo_n;
  logic [D_W-1:0]   rem_q, rem_n;
  logic [D_W-1:0]   dvs_q, dvs_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             active_q, active_n;
  logic             ready_q, ready_n;
  logic [D_W:0]     shifted;
  logic [D_W:0]     trial;
  logic             fits;
  logic             upd_en;

  always_comb begin
    shifted = {rem_q, quo_q[N_W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = ~trial[D_W];
    quo_n    = quo_q;
    rem_n    = rem_q;
    dvs_n    = dvs_q;
    cnt_n    = cnt_q;
    active_n = active_q;
    ready_n  = 1'b0;
    if (go_i) begin
      quo_n    = dividend_i;
      rem_n    = '0;
      dvs_n    = divisor_i;
      cnt_n    = CNT_W'(N_W);
      active_n = 1'b1;
    end else if (active_q) begin
      rem_n = fits ? trial[D_W-1:0] : shifted[D_W-1:0];
      quo_n = {quo_q[N_W-2:0], fits};
      cnt_n = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        active_n = 1'b0;
        ready_n  = 1'b1;
      end
    end
  end

  assign upd_en = go_i | active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q    <= '0;
      rem_q    <= '0;
      dvs_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      ready_q <= ready_n;
      if (upd_en) begin
        quo_q    <= quo_n;
        rem_q    <= rem_n;
        dvs_q    <= dvs_n;
        cnt_q    <= cnt_n;
        active_q <= active_n;
      end
    end
  end

  assign quot_o  = quo_q[O_W-1:0];
  assign ready_o = ready_q;

endmodule

// File: rtl/fsyn_best.sv
module fsyn_best
  import fsyn_pkg::*;
#(
  parameter int unsigned Q_W = 17,
  parameter int unsigned T_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cand_i,
  input  logic [Q_W-1:0]    rate_i,
  input  logic [T_W-1:0]    target_i,
  input  logic [CODE_W-1:0] mult_i,
  input  logic [CODE_W-1:0] div_i,
  output logic [CODE_W-1:0] best_mult_o,
  output logic [CODE_W-1:0] best_div_o
);

  localparam int unsigned E_W = max_u(Q_W, T_W) + 1;

  logic [E_W-1:0]    rate_x, tgt_x, err;
  logic [E_W-1:0]    berr_q, berr_n;
  logic [CODE_W-1:0] bm_q, bm_n, bd_q, bd_n;
  logic              take;
  logic              upd_en;

  always_comb begin
    rate_x = E_W'(rate_i);
    tgt_x  = E_W'(target_i);
    err    = (rate_x >= tgt_x) ? (rate_x - tgt_x) : (tgt_x - rate_x);
    take   = cand_i && (err <= berr_q);
    berr_n = berr_q;
    bm_n   = bm_q;
    bd_n   = bd_q;
    if (clear_i) begin
      berr_n = '1;
      bm_n   = '0;
      bd_n   = '0;
    end else if (take) begin
      berr_n = err;
      bm_n   = mult_i;
      bd_n   = div_i;
    end
  end

  assign upd_en = clear_i | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr_q <= '1;
      bm_q   <= '0;
      bd_q   <= '0;
    end else if (upd_en) begin
      berr_q <= berr_n;
      bm_q   <= bm_n;
      bd_q   <= bd_n;
    end
  end

  assign best_mult_o = bm_q;
  assign best_div_o  = bd_q;

endmodule

// File: rtl/fsyn_encode.sv
module fsyn_encode
  import fsyn_pkg::*;
(
  input  logic [CODE_W-1:0] mult_i,
  input  logic [CODE_W-1:0] div_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned IN_W = CODE_W + 1;
  localparam logic [IN_W-1:0] LIMIT = IN_W'((1 << CODE_W) - 1);

  logic [IN_W-1:0]   mx, dx, ms, ds;
  logic [CODE_W-1:0] mf, df;

  always_comb begin
    mx = {1'b0, mult_i};
    dx = {1'b0, div_i};
    ms = (mx == '0) ? IN_W'(1) : ((mx > LIMIT) ? LIMIT : mx);
    ds = (dx == '0) ? IN_W'(1) : ((dx > LIMIT) ? LIMIT : dx);
    mf = CODE_W'(ms - IN_W'(1));
    df = CODE_W'(ds - IN_W'(1));
    word_o = '0;
    word_o[MULT_LSB +: CODE_W] = mf;
    word_o[0 +: CODE_W]        = df;
  end

endmodule

// File: rtl/fsyn_search.sv
module fsyn_search
  import fsyn_pkg::*;
#(
  parameter int unsigned FREF_W    = 20,
  parameter int unsigned TGT_W     = 20,
  parameter int unsigned CODE_MAX  = 63,
  parameter int unsigned SCALE_DIV = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREF_W-1:0] fref_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [13:0]       word_o
);

  localparam int unsigned NUM_W = FREF_W + CODE_W;
  localparam int unsigned SD_W  = $clog2(SCALE_DIV + 1);
  localparam int unsigned Q_W   = NUM_W - SD_W + 1;
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] ONE_CODE = CODE_W'(1);

  fsyn_state_e       state_q, state_n;
  logic [FREF_W-1:0] fref_q, fref_n;
  logic [TGT_W-1:0]  tgt_q, tgt_n;
  logic [CODE_W-1:0] m_q, m_n, d_q, d_n;
  logic [Q_W-1:0]    scaled_q, scaled_n;
  logic [WORD_W-1:0] word_q, enc_word;
  logic              done_q;

  logic              scale_go, scale_rdy;
  logic [Q_W-1:0]    scale_quot;
  logic              rate_go, rate_rdy;
  logic [Q_W-1:0]    rate_quot;
  logic              clear_best, cand;
  logic [CODE_W-1:0] best_m, best_d;
  logic [NUM_W-1:0]  product;
  logic              word_en;
  logic              ctl_en;

  assign product = NUM_W'(m_q) * NUM_W'(fref_q);

  fsyn_divider #(.N_W(NUM_W), .D_W(SD_W), .O_W(Q_W)) u_div_scale (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (scale_go),
    .dividend_i (product),
    .divisor_i  (SD_W'(SCALE_DIV)),
    .quot_o     (scale_quot),
    .ready_o    (scale_rdy)
  );

  fsyn_divider #(.N_W(Q_W), .D_W(CODE_W), .O_W(Q_W)) u_div_rate (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (rate_go),
    .dividend_i (scaled_q),
    .divisor_i  (d_q),
    .quot_o     (rate_quot),
    .ready_o    (rate_rdy)
  );

  fsyn_best #(.Q_W(Q_W), .T_W(TGT_W)) u_best (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_best),
    .cand_i      (cand),
    .rate_i      (rate_quot),
    .target_i    (tgt_q),
    .mult_i      (m_q),
    .div_i       (d_q),
    .best_mult_o (best_m),
    .best_div_o  (best_d)
  );

  fsyn_encode u_enc (
    .mult_i (best_m),
    .div_i  (best_d),
    .word_o (enc_word)
  );

  always_comb begin
    state_n    = state_q;
    fref_n     = fref_q;
    tgt_n      = tgt_q;
    m_n        = m_q;
    d_n        = d_q;
    scaled_n   = scaled_q;
    scale_go   = 1'b0;
    rate_go    = 1'b0;
    clear_best = 1'b0;
    cand       = 1'b0;
    word_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          fref_n     = fref_i;
          tgt_n      = target_i;
          m_n        = TOP_CODE;
          clear_best = 1'b1;
          state_n    = ST_LOAD_M;
        end
      end
      ST_LOAD_M: begin
        scale_go = 1'b1;
        state_n  = ST_WAIT_M;
      end
      ST_WAIT_M: begin
        if (scale_rdy) begin
          scaled_n = scale_quot;
          d_n      = TOP_CODE;
          state_n  = ST_LOAD_D;
        end
      end
      ST_LOAD_D: begin
        rate_go = 1'b1;
        state_n = ST_WAIT_D;
      end
      ST_WAIT_D: begin
        if (rate_rdy) begin
          cand = 1'b1;
          if (d_q == ONE_CODE) begin
            if (m_q == ONE_CODE) begin
              state_n = ST_FINISH;
            end else begin
              m_n     = m_q - ONE_CODE;
              state_n = ST_LOAD_M;
            end
          end else begin
            d_n     = d_q - ONE_CODE;
            state_n = ST_LOAD_D;
          end
        end
      end
      ST_FINISH: begin
        word_en = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_q != ST_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fref_q   <= '0;
      tgt_q    <= '0;
      m_q      <= '0;
      d_q      <= '0;
      scaled_q <= '0;
    end else if (ctl_en) begin
      state_q  <= state_n;
      fref_q   <= fref_n;
      tgt_q    <= tgt_n;
      m_q      <= m_n;
      d_q      <= d_n;
      scaled_q <= scaled_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= word_en;
      if (word_en) begin
        word_q <= enc_word;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign word_o = word_q;

endmodule

// File: rtl/fsyn_search_chk.sv
module fsyn_search_chk #(
  parameter int unsigned CODE_MAX = 63
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [13:0] word_o
);

  localparam logic [5:0] TOP_FIELD = 6'(CODE_MAX - 1);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (busy_o || done_o));

  assert_field_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o[13:8] <= TOP_FIELD) && (word_o[5:0] <= TOP_FIELD) && (word_o[7:6] == 2'b00));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(word_o));

endmodule

bind fsyn_search fsyn_search_chk #(.CODE_MAX(CODE_MAX)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .word_o  (word_o)
);

// File: tb/fsyn_search_test.sv
module fsyn_search_test;

  localparam int unsigned FW = 20;
  localparam int unsigned TW = 20;

  logic clk;
  logic rst_n;
  logic          a_start, b_start;
  logic [FW-1:0] a_fref, b_fref;
  logic [TW-1:0] a_tgt, b_tgt;
  logic          a_busy, b_busy, a_done, b_done;
  logic [13:0]   a_word, b_word;

  int n_checks;
  int n_fail;
  bit finished;

  fsyn_search uut (
    .clk(clk), .rst_n(rst_n), .start_i(a_start), .fref_i(a_fref), .target_i(a_tgt),
    .busy_o(a_busy), .done_o(a_done), .word_o(a_word)
  );

  fsyn_search #(.CODE_MAX(15)) uut_small (
    .clk(clk), .rst_n(rst_n), .start_i(b_start), .fref_i(b_fref), .target_i(b_tgt),
    .busy_o(b_busy), .done_o(b_done), .word_o(b_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint model(input longint fref, input longint tgt, input int maxc);
    longint best = 64'h7fff_ffff_ffff_ffff;
    int bm = 0;
    int bd = 0;
    for (int m = maxc; m >= 1; m--) begin
      for (int d = maxc; d >= 1; d--) begin
        longint f = ((m * fref) / 1000) / d;
        longint e = (f >= tgt) ? f - tgt : tgt - f;
        if (e <= best) begin
          best = e;
          bm = m;
          bd = d;
        end
      end
    end
    return ((bm - 1) << 8) | (bd - 1);
  endfunction

  task automatic run_small(input longint fref, input longint tgt, input string req,
                           input bit restart_mid);
    longint exp;
    logic [13:0] got;
    exp = model(fref, tgt, 15);
    @(negedge clk);
    b_start = 1'b1; b_fref = FW'(fref); b_tgt = TW'(tgt);
    @(negedge clk);
    b_start = 1'b0;
    b_fref = FW'($urandom); b_tgt = TW'($urandom);
    check(b_busy === 1'b1, "R2 busy after start", longint'(b_busy), 1);
    if (restart_mid) begin
      repeat (500) @(negedge clk);
      b_start = 1'b1; b_fref = 20'd1000; b_tgt = 20'd0;
      @(negedge clk);
      b_start = 1'b0;
      check(b_busy === 1'b1, "R3 still busy after second start", longint'(b_busy), 1);
    end
    while (b_done !== 1'b1) @(negedge clk);
    got = b_word;
    check(b_word == 14'(exp), req, longint'(b_word), exp);
    check(b_busy === 1'b0, "R9 busy low with done", longint'(b_busy), 0);
    @(negedge clk);
    check(b_done === 1'b0, "R9 done one cycle", longint'(b_done), 0);
    repeat (3) @(negedge clk);
    check(b_word == got, "R9 word held", longint'(b_word), longint'(got));
  endtask

  initial begin
    n_checks = 0; n_fail = 0; finished = 0;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    a_start = 0; b_start = 0; a_fref = 0; b_fref = 0; a_tgt = 0; b_tgt = 0;
    repeat (3) @(negedge clk);
    check(a_busy === 1'b0 && a_done === 1'b0 && a_word == 14'h0, "R1 reset state", longint'(a_word), 0);
    check(b_busy === 1'b0 && b_done === 1'b0 && b_word == 14'h0, "R1 reset state small", longint'(b_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(a_busy === 1'b0 && a_done === 1'b0 && a_word == 14'h0, "R1 after release", longint'(a_word), 0);
    fork
      begin
        @(negedge clk);
        a_start = 1'b1; a_fref = 20'hFFFFF; a_tgt = 20'hFFFFF;
        @(negedge clk);
        a_start = 1'b0; a_fref = 20'd5; a_tgt = 20'd0;
        check(a_busy === 1'b1, "R2 busy after start full", longint'(a_busy), 1);
        while (a_done !== 1'b1) @(negedge clk);
        check(a_word == 14'h3E00, "R8 top pair encoding", longint'(a_word), 64'h3E00);
        check(a_word == 14'(model(20'hFFFFF, 20'hFFFFF, 63)), "R5 full scan reaches top", longint'(a_word),
              model(20'hFFFFF, 20'hFFFFF, 63));
      end
      begin
        run_small(1000, 0, "R7 tie picks smallest pair", 1'b0);
        check(b_word == 14'h001, "R7 tie word literal", longint'(b_word), 1);
        run_small(20'hFFFFF, 20'hFFFFF, "R5 small scan top", 1'b0);
        check(b_word == 14'h0E00, "R8 encoding small top", longint'(b_word), 64'h0E00);
        run_small(1000000, 1857, "R4 exact rate", 1'b0);
        run_small(777777, 4321, "R3 start while busy ignored", 1'b1);
        for (int i = 0; i < 9; i++) begin
          longint fr, tg;
          fr = longint'($urandom_range(1000, 20'hFFFFF));
          tg = longint'($urandom_range(0, 32'(15 * fr / 1000 + 50)));
          run_small(fr, tg, "R6 random best match", 1'b0);
        end
      end
    join
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule